// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block carries out the status changes a processor core makes when it takes an exception and when it later returns from one. Seven request lines are sampled on each clock edge: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. When one or more requests are live, the block chooses the winner by a fixed priority. A normal or fast interrupt takes part only while its disable bit in the current status word is clear.

For the chosen exception, the block issues one set of write strobes in a single cycle. The old status word goes to the saved status register of the target mode. The return address goes to that mode's link register. The new status word has the mode switched, interrupts masked and the compact-instruction state bit cleared. The program counter is loaded with the exception vector. The block keeps its own copy of the saved status and link value for each exception mode. A return request can therefore restore the status word and the program counter from the bank selected by the current mode.

All outputs are registered. Requests sampled at edge N appear on the outputs after edge N, and the write strobes last exactly one cycle.

Top module: `exc_seq`

## Requirements
- R1: Simultaneous requests are served in the order reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. `taken_kind` reports the winner as a code that equals its vector slot: reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, normal interrupt 6, fast interrupt 7.
- R2: A normal interrupt request is ignored while bit 7 of `cur_psr` is set. With no other request live, no strobe rises.
- R3: A fast interrupt request is ignored while bit 6 of `cur_psr` is set. With no other request live, no strobe rises.
- R4: On entry, `spsr_we` pulses with `spsr_wdata` equal to the sampled `cur_psr`. `spsr_mode` is the target mode.
- R5: On entry, `psr_new` keeps bits 31:8 of `cur_psr`, clears bit 5 (compact-instruction state) and sets bits 4:0 to the target mode. The target modes are: supervisor 0x13 for reset and software interrupt, undefined 0x1B, abort 0x17 for both aborts, normal interrupt 0x12, fast interrupt 0x11.
- R6: On entry, bit 7 of `psr_new` is always set. Bit 6 is set for reset and fast interrupt, and is copied from `cur_psr` for every other exception.
- R7: On entry, `lr_we` pulses with `lr_wdata` equal to the sampled `ret_addr`. `lr_mode` is the target mode.
- R8: On entry, `pc_we` pulses and `pc_new` is the vector base plus 4 times the exception code.
- R9: The vector base is 0xFFFF0000 when `hivec` is 1 and 0x00000000 when it is 0.
- R10: A return request with no exception live, made in one of the five exception modes, pulses `psr_we` and `pc_we`. The pulse carries the last saved status and link value written for that mode, including a write made on the edge just before. `spsr_we` and `lr_we` stay low.
- R11: A return request in user (0x10) or system (0x1F) mode has no effect. A return request that coincides with a live exception is overridden by the exception entry.
- R12: While reset is low, all strobes are 0. A request held for one cycle yields strobes for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_reset | input | 1 | Reset exception request |
| exc_undef | input | 1 | Undefined instruction request |
| exc_swi | input | 1 | Software interrupt request |
| exc_pabt | input | 1 | Prefetch abort request |
| exc_dabt | input | 1 | Data abort request |
| exc_irq | input | 1 | Normal interrupt request |
| exc_fiq | input | 1 | Fast interrupt request |
| ret_req | input | 1 | Return-from-exception request |
| cur_psr | input | 32 | Current status word |
| ret_addr | input | 32 | Return address for the link register |
| hivec | input | 1 | Select high vector base |
| spsr_we | output | 1 | Saved status write strobe |
| spsr_mode | output | 5 | Mode whose saved status is written |
| spsr_wdata | output | 32 | Saved status data |
| lr_we | output | 1 | Link register write strobe |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_wdata | output | 32 | Link register data |
| psr_we | output | 1 | Status word write strobe |
| psr_new | output | 32 | New status word |
| pc_we | output | 1 | Program counter write strobe |
| pc_new | output | 32 | New program counter |
| taken | output | 1 | Exception entry performed this cycle |
| taken_kind | output | 3 | Code of the exception taken |

## Verification
The bench builds the block with its defaults: 32-bit data, a 0xFFFF0000 high base and a vector stride of 4. With these values every vector address and every status bit position can be checked against literal constants. Five banks are enough to reach a return from each exception mode. The vector table covers every request alone and masked, and the overlapping combinations that decide each step of the priority order. The directed tests then cover returns from every bank, an ignored return from user mode, a return that loses to an interrupt, and a return issued in the cycle right after the entry that filled its bank.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int NUM_KINDS = 8;
  localparam int KIND_W    = 3;
  localparam int MODE_W    = 5;
  localparam int NUM_BANKS = 5;
  localparam int BIDX_W    = $clog2(NUM_BANKS);

  // status word bit positions
  localparam int PSR_I = 7;
  localparam int PSR_F = 6;
  localparam int PSR_T = 5;

  // exception code doubles as the vector slot index
  localparam logic [KIND_W-1:0] K_RESET = 3'd0;
  localparam logic [KIND_W-1:0] K_UNDEF = 3'd1;
  localparam logic [KIND_W-1:0] K_SWI   = 3'd2;
  localparam logic [KIND_W-1:0] K_PABT  = 3'd3;
  localparam logic [KIND_W-1:0] K_DABT  = 3'd4;
  localparam logic [KIND_W-1:0] K_RSVD  = 3'd5;
  localparam logic [KIND_W-1:0] K_IRQ   = 3'd6;
  localparam logic [KIND_W-1:0] K_FIQ   = 3'd7;

  localparam logic [MODE_W-1:0] M_USR = 5'h10;
  localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] M_SVC = 5'h13;
  localparam logic [MODE_W-1:0] M_ABT = 5'h17;
  localparam logic [MODE_W-1:0] M_UND = 5'h1B;
  localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

  // highest priority first
  localparam int NUM_PRIO = 7;
  localparam logic [KIND_W-1:0] PRIO_ORDER [NUM_PRIO] =
    '{K_RESET, K_DABT, K_FIQ, K_IRQ, K_PABT, K_UNDEF, K_SWI};

  typedef struct packed {
    logic              valid;
    logic [BIDX_W-1:0] idx;
  } bank_sel_t;

  function automatic logic [MODE_W-1:0] target_mode(input logic [KIND_W-1:0] k);
    case (k)
      K_RESET, K_SWI: target_mode = M_SVC;
      K_UNDEF:        target_mode = M_UND;
      K_PABT, K_DABT: target_mode = M_ABT;
      K_IRQ:          target_mode = M_IRQ;
      K_FIQ:          target_mode = M_FIQ;
      default:        target_mode = M_SVC;
    endcase
  endfunction

  function automatic logic masks_fast(input logic [KIND_W-1:0] k);
    masks_fast = (k == K_RESET) || (k == K_FIQ);
  endfunction

  function automatic bank_sel_t bank_of(input logic [MODE_W-1:0] m);
    bank_sel_t s;
    s.valid = 1'b1;
    case (m)
      M_FIQ:   s.idx = BIDX_W'(0);
      M_IRQ:   s.idx = BIDX_W'(1);
      M_SVC:   s.idx = BIDX_W'(2);
      M_ABT:   s.idx = BIDX_W'(3);
      M_UND:   s.idx = BIDX_W'(4);
      default: begin s.valid = 1'b0; s.idx = '0; end
    endcase
    return s;
  endfunction

  function automatic logic [31:0] entry_status(input logic [31:0] cur,
                                               input logic [KIND_W-1:0] k);
    logic [31:0] r;
    r        = cur;
    r[4:0]   = target_mode(k);
    r[PSR_T] = 1'b0;
    r[PSR_I] = 1'b1;
    if (masks_fast(k)) r[PSR_F] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
  import exc_seq_pkg::*;
(
  input  logic [NUM_KINDS-1:0] req,
  input  logic                 irq_masked,
  input  logic                 fiq_masked,
  output logic                 any,
  output logic [KIND_W-1:0]    kind
);

  logic [NUM_KINDS-1:0] live;

  always_comb begin
    live         = req;
    live[K_IRQ]  = req[K_IRQ] & ~irq_masked;
    live[K_FIQ]  = req[K_FIQ] & ~fiq_masked;
    live[K_RSVD] = 1'b0;
  end

  // walk from lowest to highest so the highest live request wins
  always_comb begin
    kind = K_RESET;
    for (int p = NUM_PRIO - 1; p >= 0; p--) begin
      if (live[PRIO_ORDER[p]]) kind = PRIO_ORDER[p];
    end
    any = |live;
  end

endmodule

// File: rtl/exc_vec.sv
module exc_vec
  import exc_seq_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter logic [DATA_W-1:0] HI_BASE  = 32'hFFFF_0000,
  parameter logic [DATA_W-1:0] LO_BASE  = '0,
  parameter int              VEC_STRIDE = 4
) (
  input  logic [KIND_W-1:0] kind,
  input  logic              hivec,
  output logic [DATA_W-1:0] addr
);

  localparam int SHIFT = $clog2(VEC_STRIDE);

  function automatic logic [DATA_W-1:0] slot_offset(input logic [KIND_W-1:0] k);
    return DATA_W'(k) << SHIFT;
  endfunction

  assign addr = (hivec ? HI_BASE : LO_BASE) + slot_offset(kind);

endmodule

// File: rtl/exc_bank.sv
module exc_bank
  import exc_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB     = NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BIDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_psr,
  input  logic [DATA_W-1:0] wr_lr,
  input  logic [BIDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_psr,
  output logic [DATA_W-1:0] rd_lr
);

  logic [NB-1:0][DATA_W-1:0] psr_all;
  logic [NB-1:0][DATA_W-1:0] lr_all;

  for (genvar g = 0; g < NB; g++) begin : g_ent
    logic [DATA_W-1:0] psr_q;
    logic [DATA_W-1:0] lr_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        psr_q <= '0;
        lr_q  <= '0;
      end else if (wr_en && (wr_idx == BIDX_W'(g))) begin
        psr_q <= wr_psr;
        lr_q  <= wr_lr;
      end
    end
    assign psr_all[g] = psr_q;
    assign lr_all[g]  = lr_q;
  end

  always_comb begin
    rd_psr = '0;
    rd_lr  = '0;
    for (int i = 0; i < NB; i++) begin
      if (rd_idx == BIDX_W'(i)) begin
        rd_psr = psr_all[i];
        rd_lr  = lr_all[i];
      end
    end
  end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] HI_BASE    = 32'hFFFF_0000,
  parameter int                VEC_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_reset,
  input  logic              exc_undef,
  input  logic              exc_swi,
  input  logic              exc_pabt,
  input  logic              exc_dabt,
  input  logic              exc_irq,
  input  logic              exc_fiq,
  input  logic              ret_req,
  input  logic [DATA_W-1:0] cur_psr,
  input  logic [DATA_W-1:0] ret_addr,
  input  logic              hivec,
  output logic              spsr_we,
  output logic [MODE_W-1:0] spsr_mode,
  output logic [DATA_W-1:0] spsr_wdata,
  output logic              lr_we,
  output logic [MODE_W-1:0] lr_mode,
  output logic [DATA_W-1:0] lr_wdata,
  output logic              psr_we,
  output logic [DATA_W-1:0] psr_new,
  output logic              pc_we,
  output logic [DATA_W-1:0] pc_new,
  output logic              taken,
  output logic [KIND_W-1:0] taken_kind
);

  // named internal events
  logic [NUM_KINDS-1:0] req_vec;
  logic                 ent_any;
  logic [KIND_W-1:0]    ent_kind;
  logic [MODE_W-1:0]    ent_mode;
  logic [DATA_W-1:0]    ent_psr;
  logic [DATA_W-1:0]    ent_pc;
  bank_sel_t            wr_sel;
  bank_sel_t            rd_sel;
  logic                 ret_go;
  logic [DATA_W-1:0]    bank_psr;
  logic [DATA_W-1:0]    bank_lr;

  always_comb begin
    req_vec          = '0;
    req_vec[K_RESET] = exc_reset;
    req_vec[K_UNDEF] = exc_undef;
    req_vec[K_SWI]   = exc_swi;
    req_vec[K_PABT]  = exc_pabt;
    req_vec[K_DABT]  = exc_dabt;
    req_vec[K_IRQ]   = exc_irq;
    req_vec[K_FIQ]   = exc_fiq;
  end

  exc_prio u_prio (
    .req        (req_vec),
    .irq_masked (cur_psr[PSR_I]),
    .fiq_masked (cur_psr[PSR_F]),
    .any        (ent_any),
    .kind       (ent_kind)
  );

  exc_vec #(
    .DATA_W     (DATA_W),
    .HI_BASE    (HI_BASE),
    .LO_BASE    ('0),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_vec (
    .kind  (ent_kind),
    .hivec (hivec),
    .addr  (ent_pc)
  );

  assign ent_mode = target_mode(ent_kind);
  assign ent_psr  = DATA_W'(entry_status(32'(cur_psr), ent_kind));
  assign wr_sel   = bank_of(ent_mode);
  assign rd_sel   = bank_of(cur_psr[MODE_W-1:0]);
  assign ret_go   = ret_req & ~ent_any & rd_sel.valid;

  exc_bank #(
    .DATA_W (DATA_W),
    .NB     (NUM_BANKS)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ent_any),
    .wr_idx (wr_sel.idx),
    .wr_psr (cur_psr),
    .wr_lr  (ret_addr),
    .rd_idx (rd_sel.idx),
    .rd_psr (bank_psr),
    .rd_lr  (bank_lr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spsr_we    <= 1'b0;
      spsr_mode  <= '0;
      spsr_wdata <= '0;
      lr_we      <= 1'b0;
      lr_mode    <= '0;
      lr_wdata   <= '0;
      psr_we     <= 1'b0;
      psr_new    <= '0;
      pc_we      <= 1'b0;
      pc_new     <= '0;
      taken      <= 1'b0;
      taken_kind <= '0;
    end else begin
      spsr_we <= 1'b0;
      lr_we   <= 1'b0;
      psr_we  <= 1'b0;
      pc_we   <= 1'b0;
      taken   <= 1'b0;
      if (ent_any) begin
        spsr_we    <= 1'b1;
        spsr_mode  <= ent_mode;
        spsr_wdata <= cur_psr;
        lr_we      <= 1'b1;
        lr_mode    <= ent_mode;
        lr_wdata   <= ret_addr;
        psr_we     <= 1'b1;
        psr_new    <= ent_psr;
        pc_we      <= 1'b1;
        pc_new     <= ent_pc;
        taken      <= 1'b1;
        taken_kind <= ent_kind;
      end else if (ret_go) begin
        psr_we  <= 1'b1;
        psr_new <= bank_psr;
        pc_we   <= 1'b1;
        pc_new  <= bank_lr;
      end
    end
  end

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
  import exc_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              exc_reset,
  input logic              exc_undef,
  input logic              exc_swi,
  input logic              exc_pabt,
  input logic              exc_dabt,
  input logic              exc_irq,
  input logic              exc_fiq,
  input logic              ret_req,
  input logic [31:0]       cur_psr,
  input logic              hivec,
  input logic              spsr_we,
  input logic [MODE_W-1:0] spsr_mode,
  input logic              lr_we,
  input logic [MODE_W-1:0] lr_mode,
  input logic              psr_we,
  input logic [31:0]       psr_new,
  input logic              pc_we,
  input logic [31:0]       pc_new,
  input logic              taken,
  input logic [KIND_W-1:0] taken_kind,
  input logic              ent_any
);

  logic others_irq;
  logic others_fiq;
  assign others_irq = exc_reset | exc_undef | exc_swi | exc_pabt | exc_dabt | exc_fiq;
  assign others_fiq = exc_reset | exc_undef | exc_swi | exc_pabt | exc_dabt | exc_irq;

  assert_reset_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    exc_reset |=> (taken && taken_kind == K_RESET));

  assert_irq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_irq && cur_psr[PSR_I] && !others_irq && !ret_req) |=> !taken && !psr_we);

  assert_fiq_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_fiq && cur_psr[PSR_F] && !others_fiq && !ret_req) |=> !taken && !psr_we);

  assert_entry_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (spsr_we && lr_we && psr_we && pc_we &&
               spsr_mode == psr_new[4:0] && lr_mode == psr_new[4:0]));

  assert_entry_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (!psr_new[PSR_T] && psr_new[PSR_I]));

  assert_vector_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (pc_new[31:16] == ($past(hivec) ? 16'hFFFF : 16'h0000)));

  assert_return_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && !taken) |-> (psr_we && !spsr_we && !lr_we));

  assert_entry_beats_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && ent_any) |=> taken);

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> taken);

endmodule

bind exc_seq exc_seq_chk u_chk (.*);

// File: tb/test_exc_seq.sv
`timescale 1ns/1ps
module test_exc_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_reset, exc_undef, exc_swi, exc_pabt, exc_dabt, exc_irq, exc_fiq;
  logic        ret_req;
  logic [31:0] cur_psr, ret_addr;
  logic        hivec;
  logic        spsr_we, lr_we, psr_we, pc_we, taken;
  logic [4:0]  spsr_mode, lr_mode;
  logic [31:0] spsr_wdata, lr_wdata, psr_new, pc_new;
  logic [2:0]  taken_kind;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_spsr [32];
  logic [31:0] m_lr   [32];

  always #4 clk = ~clk;

  exc_seq i_exc_seq (
    .clk(clk), .rst_n(rst_n),
    .exc_reset(exc_reset), .exc_undef(exc_undef), .exc_swi(exc_swi),
    .exc_pabt(exc_pabt), .exc_dabt(exc_dabt), .exc_irq(exc_irq), .exc_fiq(exc_fiq),
    .ret_req(ret_req), .cur_psr(cur_psr), .ret_addr(ret_addr), .hivec(hivec),
    .spsr_we(spsr_we), .spsr_mode(spsr_mode), .spsr_wdata(spsr_wdata),
    .lr_we(lr_we), .lr_mode(lr_mode), .lr_wdata(lr_wdata),
    .psr_we(psr_we), .psr_new(psr_new), .pc_we(pc_we), .pc_new(pc_new),
    .taken(taken), .taken_kind(taken_kind)
  );

  // {fiq,irq,dabt,pabt,swi,undef,reset}, cur_psr, hivec, taken, kind
  localparam int NV = 18;
  localparam logic [43:0] VEC [NV] = '{
    {7'b0000001, 32'hF00000D0, 1'b0, 1'b1, 3'd0},
    {7'b0000010, 32'h60000010, 1'b0, 1'b1, 3'd1},
    {7'b0000100, 32'h00000030, 1'b0, 1'b1, 3'd2},
    {7'b0001000, 32'h80000010, 1'b0, 1'b1, 3'd3},
    {7'b0010000, 32'h20000010, 1'b1, 1'b1, 3'd4},
    {7'b0100000, 32'h00000010, 1'b0, 1'b1, 3'd6},
    {7'b0100000, 32'h00000090, 1'b0, 1'b0, 3'd0},
    {7'b1000000, 32'h00000013, 1'b1, 1'b1, 3'd7},
    {7'b1000000, 32'h00000050, 1'b0, 1'b0, 3'd0},
    {7'b1111111, 32'h00000010, 1'b1, 1'b1, 3'd0},
    {7'b1111110, 32'h00000010, 1'b0, 1'b1, 3'd4},
    {7'b1101000, 32'h00000010, 1'b0, 1'b1, 3'd7},
    {7'b0101100, 32'h00000010, 1'b0, 1'b1, 3'd6},
    {7'b0001010, 32'h00000010, 1'b1, 1'b1, 3'd3},
    {7'b0000110, 32'h10000010, 1'b0, 1'b1, 3'd1},
    {7'b1100000, 32'h00000050, 1'b0, 1'b1, 3'd6},
    {7'b0101000, 32'h00000090, 1'b0, 1'b1, 3'd3},
    {7'b1100000, 32'h000000D0, 1'b0, 1'b0, 3'd0}
  };

  function automatic logic [4:0] exp_mode(input logic [2:0] k);
    case (k)
      3'd1:    return 5'h1B;
      3'd3:    return 5'h17;
      3'd4:    return 5'h17;
      3'd6:    return 5'h12;
      3'd7:    return 5'h11;
      default: return 5'h13;
    endcase
  endfunction

  function automatic logic [31:0] exp_status(input logic [31:0] c, input logic [2:0] k);
    logic fbit;
    fbit = (k == 3'd0 || k == 3'd7) ? 1'b1 : c[6];
    return {c[31:8], 1'b1, fbit, 1'b0, exp_mode(k)};
  endfunction

  function automatic logic [31:0] exp_vector(input logic h, input logic [2:0] k);
    return (h ? 32'hFFFF0000 : 32'h0) | {27'd0, k, 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {exc_fiq, exc_irq, exc_dabt, exc_pabt, exc_swi, exc_undef, exc_reset} = 7'b0;
    ret_req = 1'b0;
  endtask

  task automatic record_entry(input logic [31:0] c, input logic [31:0] ra, input logic [2:0] k);
    m_spsr[exp_mode(k)] = c;
    m_lr[exp_mode(k)]   = ra;
  endtask

  task automatic do_return(input logic [4:0] mode, input string tag);
    @(negedge clk);
    idle_inputs();
    cur_psr = {24'h0000A0, 3'b000, mode};
    ret_req = 1'b1;
    @(negedge clk);
    chk({tag, " psr_we"}, {31'd0, psr_we}, 32'd1);
    chk({tag, " psr_new"}, psr_new, m_spsr[mode]);
    chk({tag, " pc_new"}, pc_new, m_lr[mode]);
    chk({tag, " no saved write"}, {30'd0, spsr_we, lr_we}, 32'd0);
    ret_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_spsr[i] = '0; m_lr[i] = '0; end
    rst_n = 1'b0;
    idle_inputs();
    cur_psr = 32'h10; ret_addr = 32'h0; hivec = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset strobes", {27'd0, spsr_we, lr_we, psr_we, pc_we, taken}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [6:0]  ex;
      logic [31:0] c;
      logic        hv, tk;
      logic [2:0]  k;
      {ex, c, hv, tk, k} = VEC[i];
      @(negedge clk);
      {exc_fiq, exc_irq, exc_dabt, exc_pabt, exc_swi, exc_undef, exc_reset} = ex;
      cur_psr  = c;
      hivec    = hv;
      ret_addr = 32'h0000_1000 + 32'(i) * 16;
      @(negedge clk);
      if (tk) begin
        chk("R1 taken", {31'd0, taken}, 32'd1);
        chk("R1 kind", {29'd0, taken_kind}, {29'd0, k});
        chk("R4 spsr_wdata", spsr_wdata, c);
        chk("R4 spsr_mode", {27'd0, spsr_mode}, {27'd0, exp_mode(k)});
        chk("R5 R6 psr_new", psr_new, exp_status(c, k));
        chk("R7 lr_wdata", lr_wdata, ret_addr);
        chk("R7 lr_mode", {27'd0, lr_mode}, {27'd0, exp_mode(k)});
        chk("R8 R9 pc_new", pc_new, exp_vector(hv, k));
        record_entry(c, ret_addr, k);
      end else begin
        chk("R2 R3 masked strobes", {27'd0, spsr_we, lr_we, psr_we, pc_we, taken}, 32'd0);
      end
      idle_inputs();
      @(negedge clk);
      // R12 one-cycle pulse
      chk("R12 pulse ends", {27'd0, spsr_we, lr_we, psr_we, pc_we, taken}, 32'd0);
    end

    // R10 returns from every exception mode
    do_return(5'h11, "R10 fiq");
    do_return(5'h12, "R10 irq");
    do_return(5'h13, "R10 svc");
    do_return(5'h17, "R10 abt");
    do_return(5'h1B, "R10 und");

    // R11 return from user and system modes is ignored
    @(negedge clk);
    cur_psr = 32'h00000010; ret_req = 1'b1;
    @(negedge clk);
    chk("R11 user return", {30'd0, psr_we, pc_we}, 32'd0);
    cur_psr = 32'h0000001F;
    @(negedge clk);
    chk("R11 system return", {30'd0, psr_we, pc_we}, 32'd0);

    // R11 exception overrides a coinciding return
    cur_psr = 32'h00000013; exc_irq = 1'b1; ret_addr = 32'h0000_7770; hivec = 1'b0;
    @(negedge clk);
    chk("R11 entry wins", {29'd0, taken, taken_kind}, {29'd0, 1'b1, 3'd6});
    chk("R11 entry pc", pc_new, 32'h18);
    record_entry(32'h00000013, 32'h0000_7770, 3'd6);
    idle_inputs();

    // R10 return right after the entry that filled the bank
    @(negedge clk);
    cur_psr = 32'h4000_0010; exc_dabt = 1'b1; ret_addr = 32'h0000_ABC0;
    @(negedge clk);
    chk("R10 b2b entry", {29'd0, taken, taken_kind}, {29'd0, 1'b1, 3'd4});
    idle_inputs();
    cur_psr = 32'h0000_00D7; ret_req = 1'b1;
    @(negedge clk);
    chk("R10 b2b psr", psr_new, 32'h4000_0010);
    chk("R10 b2b pc", pc_new, 32'h0000_ABC0);
    idle_inputs();
    @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule